// File: doc/BRIEF.md
# Video Memory Block Copier

This block copies data from system memory into the video-RAM window. Software sets it up through five byte-wide registers: a 16-bit source address, a 16-bit destination address (each written as a high byte and a low byte) and a control register. A write to the control register starts a transfer, and its top bit picks one of two modes.

In general mode the whole block moves at once. The engine copies one byte in every cycle in which the memory grant is high. In blanking mode the engine moves one 16-byte chunk for each rising edge of the `hblank` input, then waits for the next edge. Each byte is read from the memory master and written to the video-RAM master in the same cycle. `busy` stays high while data is moving, so an external arbiter can hold off the processor. Reading the control register returns the number of chunks still to move and an idle flag. Writing it can also stop a blanking-mode transfer part way through.

Top module: `vdma_engine`

## Requirements
- R1: A write to a low address byte (register index 1 = source low, 3 = destination low) stores bits [7:4] of the data and forces bits [3:0] to zero. Every transfer therefore starts on a 16-byte boundary.
- R2: When a transfer starts, destination bits [15:13] are forced to 100 and bits [12:0] are kept. The destination counter wraps inside 0x8000–0x9FFF, so every video-RAM write address lies in that window.
- R3: A start write to the control register (index 4) loads a length of (bits[6:0] + 1) × 16 bytes, from 16 to 2048 bytes.
- R4: Control bit 7 selects the mode: 0 is general mode (the whole block at once) and 1 is blanking mode (16-byte chunks).
- R5: In general mode, each cycle with `mem_gnt` high moves one byte. `mem_rdata` is written to video RAM at the destination counter, and both counters then increment. The transfer stops after the last byte.
- R6: In blanking mode, each rising edge of `hblank` moves exactly 16 bytes. A level held high does not start a second burst, and no byte moves between bursts.
- R7: Writing the control register with bit 7 = 0 during an active blanking-mode transfer cancels it: the remaining count becomes zero, the transfer goes idle and no new transfer starts. The same write at any other time starts a general-mode transfer.
- R8: Reading index 4 returns {~active, (remaining_bytes/16 − 1) truncated to 7 bits}. Reading any other index returns 0xFF.
- R9: After reset nothing is active, `busy`, `mem_req` and `vram_we` are low, and the status read returns 0xFF.
- R10: Writes to the address registers during a transfer do not change the addresses the transfer uses. The working counters load only at start.
- R11: `busy` and `mem_req` are high only while a general transfer or a blanking burst is moving data. `vram_we` is high only when `busy` and `mem_gnt` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory grant; one byte moves per granted cycle |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid in the granted cycle |
| vram_we | output | 1 | Video-RAM write strobe |
| vram_addr | output | 16 | Video-RAM write address |
| vram_wdata | output | 8 | Video-RAM write data |
| hblank | input | 1 | Blanking strobe; a rising edge starts a chunk |
| busy | output | 1 | Data is moving |

## Verification
General mode is tried three ways. A held grant shows the copy order and that data lands at the right offsets. A grant toggling every cycle shows that exactly one byte moves per granted cycle. The full 2048-byte length shows that the maximum length decodes correctly and that the destination wraps inside the window. Blanking mode is driven with a long-held strobe and then a second separate edge: the first separates edge triggering from level triggering, and the chunk and idle readbacks show the count falls by 16 per burst. A cancel in the middle of a blanking transfer, followed by the same control write while idle, shows the difference between stopping a transfer and starting one. Rewriting the address registers while the grant is withheld shows that the working counters stay separate from the registers.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned RA_W     = 3;
    localparam int unsigned CHUNK_LG = 4;
    localparam int unsigned CNT_W    = 7;
    localparam int unsigned LEN_W    = CNT_W + CHUNK_LG + 1;
    localparam int unsigned VWIN_LG  = 13;
    localparam int unsigned TOP_W    = ADDR_W - VWIN_LG;

    localparam logic [TOP_W-1:0]  VRAM_TOP  = 3'b100;
    localparam logic [LEN_W-1:0]  MIN_BYTES = LEN_W'(1) << CHUNK_LG;
    localparam logic [LEN_W-1:0]  MAX_BYTES = LEN_W'(1) << (CNT_W + CHUNK_LG);

    localparam logic [RA_W-1:0] RA_SRC_HI = 3'd0;
    localparam logic [RA_W-1:0] RA_SRC_LO = 3'd1;
    localparam logic [RA_W-1:0] RA_DST_HI = 3'd2;
    localparam logic [RA_W-1:0] RA_DST_LO = 3'd3;
    localparam logic [RA_W-1:0] RA_CTL    = 3'd4;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_HBL = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic             start;
        logic             cancel;
        xfer_mode_e       mode;
        logic [CNT_W-1:0] chunks_m1;
    } ctl_cmd_t;

    function automatic logic [LEN_W-1:0] bytes_from_code(input logic [CNT_W-1:0] code);
        return (LEN_W'(code) + LEN_W'(1)) << CHUNK_LG;
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic act,
                                                      input logic [LEN_W-1:0] rem);
        logic [LEN_W-1:0] units;
        units = (rem >> CHUNK_LG) - LEN_W'(1);
        return {~act, units[CNT_W-1:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] win_addr(input logic [ADDR_W-1:0] a);
        return {VRAM_TOP, a[VWIN_LG-1:0]};
    endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RA_W-1:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    input  xfer_mode_e        mode,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output ctl_cmd_t          cmd
);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic              ctl_hit;

    assign ctl_hit       = we && (addr == RA_CTL);
    assign cmd.cancel    = ctl_hit && !wdata[DATA_W-1] && active && (mode == MODE_HBL);
    assign cmd.start     = ctl_hit && !cmd.cancel;
    assign cmd.mode      = xfer_mode_e'(wdata[DATA_W-1]);
    assign cmd.chunks_m1 = wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (we) begin
            case (addr)
                RA_SRC_HI: src_q[ADDR_W-1:DATA_W] <= wdata;
                RA_SRC_LO: src_q[DATA_W-1:0]      <= {wdata[DATA_W-1:CHUNK_LG], CHUNK_LG'(0)};
                RA_DST_HI: dst_q[ADDR_W-1:DATA_W] <= wdata;
                RA_DST_LO: dst_q[DATA_W-1:0]      <= {wdata[DATA_W-1:CHUNK_LG], CHUNK_LG'(0)};
                RA_CTL:    if (cmd.start) dst_q   <= win_addr(dst_q);
                default:   ;
            endcase
        end
    end

    assign src_base = src_q;
    assign dst_base = dst_q;

    AST_DST_FORCED: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> (dst_q[ADDR_W-1:VWIN_LG] == VRAM_TOP)) // R2
        else $error("destination not forced into window");

    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == RA_SRC_LO)) |=> (src_q[CHUNK_LG-1:0] == '0)) // R1
        else $error("source low bits kept");

endmodule

// File: rtl/vdma_hb_edge.sv
module vdma_hb_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level && !level_q;

endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_cmd_t          cmd,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              hb_rise,
    input  logic              gnt,
    output logic              active,
    output xfer_mode_e        mode,
    output logic [LEN_W-1:0]  rem,
    output logic              busy,
    output logic              move,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    logic                active_q;
    xfer_mode_e          mode_q;
    logic [LEN_W-1:0]    rem_q;
    logic                burst_q;
    logic [CHUNK_LG-1:0] beat_q;
    logic [ADDR_W-1:0]   src_w;
    logic [ADDR_W-1:0]   dst_w;
    logic                last_byte;
    logic                burst_go;

    assign busy      = active_q && ((mode_q == MODE_GEN) || burst_q);
    assign move      = busy && gnt;
    assign last_byte = (rem_q == LEN_W'(1));
    assign burst_go  = active_q && (mode_q == MODE_HBL) && !burst_q && hb_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            mode_q   <= MODE_GEN;
            rem_q    <= '0;
            burst_q  <= 1'b0;
            beat_q   <= '0;
            src_w    <= '0;
            dst_w    <= '0;
        end else if (cmd.cancel) begin
            active_q <= 1'b0;
            rem_q    <= '0;
            burst_q  <= 1'b0;
        end else if (cmd.start) begin
            active_q <= 1'b1;
            mode_q   <= cmd.mode;
            rem_q    <= bytes_from_code(cmd.chunks_m1);
            burst_q  <= 1'b0;
            beat_q   <= '0;
            src_w    <= src_base;
            dst_w    <= win_addr(dst_base);
        end else begin
            if (burst_go) begin
                burst_q <= 1'b1;
                beat_q  <= '0;
            end
            if (move) begin
                src_w  <= src_w + ADDR_W'(1);
                dst_w  <= win_addr(dst_w + ADDR_W'(1));
                rem_q  <= rem_q - LEN_W'(1);
                beat_q <= beat_q + CHUNK_LG'(1);
                if (last_byte) active_q <= 1'b0;
                if (&beat_q)   burst_q  <= 1'b0;
            end
        end
    end

    assign active   = active_q;
    assign mode     = mode_q;
    assign rem      = rem_q;
    assign src_addr = src_w;
    assign dst_addr = dst_w;

    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (src_w[CHUNK_LG-1:0] == '0 && dst_w[CHUNK_LG-1:0] == '0)) // R1
        else $error("unaligned start of movement");

    AST_LEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> (active_q && rem_q >= MIN_BYTES && rem_q <= MAX_BYTES)) // R3
        else $error("length out of range after start");

    AST_ACTIVE_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (rem_q != '0)) // R5
        else $error("active with nothing left");

    AST_BURST_SIZE: assert property (@(posedge clk) disable iff (rst)
        (burst_q && move && (&beat_q) && !cmd.start && !cmd.cancel)
            |=> (!burst_q && rem_q[CHUNK_LG-1:0] == '0)) // R6
        else $error("burst did not end on a chunk boundary");

    AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
        cmd.cancel |=> (!active_q && rem_q == '0 && !busy)) // R7
        else $error("cancel left transfer running");

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              vram_we,
    output logic [ADDR_W-1:0] vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    input  logic              hblank,
    output logic              busy
);

    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;
    ctl_cmd_t          cmd;
    logic              active;
    xfer_mode_e        mode;
    logic [LEN_W-1:0]  rem;
    logic              hb_rise;
    logic              move;

    vdma_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .active   (active),
        .mode     (mode),
        .src_base (src_base),
        .dst_base (dst_base),
        .cmd      (cmd)
    );

    vdma_hb_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (hblank),
        .rise  (hb_rise)
    );

    vdma_mover u_mover (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .src_base (src_base),
        .dst_base (dst_base),
        .hb_rise  (hb_rise),
        .gnt      (mem_gnt),
        .active   (active),
        .mode     (mode),
        .rem      (rem),
        .busy     (busy),
        .move     (move),
        .src_addr (mem_addr),
        .dst_addr (vram_addr)
    );

    assign reg_rdata  = (reg_addr == RA_CTL) ? status_byte(active, rem) : {DATA_W{1'b1}};
    assign mem_req    = busy;
    assign vram_we    = move;
    assign vram_wdata = mem_rdata;

    AST_VRAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> (vram_addr[ADDR_W-1:VWIN_LG] == VRAM_TOP)) // R2
        else $error("write outside video window");

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!vram_we && !mem_req)) // R11
        else $error("activity while not busy");

endmodule

// File: tb/test_vdma_engine.sv
module test_vdma_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic        mem_gnt = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        vram_we;
    logic [15:0] vram_addr;
    logic [7:0]  vram_wdata;
    logic        hblank = 1'b0;
    logic        busy;

    int nchk = 0;
    int nerr = 0;
    int wcnt = 0;
    logic [7:0] vmem [0:8191];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = pat(mem_addr);

    vdma_engine i_vdma_engine (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .hblank(hblank), .busy(busy)
    );

    always @(posedge clk) begin
        if (vram_we) begin
            vmem[vram_addr[12:0]] <= vram_wdata;
            wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd4;
    endtask

    task automatic setup(input logic [15:0] src, input logic [15:0] dst);
        wr(3'd0, src[15:8]); wr(3'd1, src[7:0]);
        wr(3'd2, dst[15:8]); wr(3'd3, dst[7:0]);
    endtask

    task automatic wait_idle(input int limit);
        for (int n = 0; n < limit && busy; n++) @(negedge clk);
    endtask

    task automatic data_chk(input string req, input logic [15:0] src,
                            input logic [12:0] dst, input int len);
        int bad = 0;
        for (int i = 0; i < len; i++)
            if (vmem[13'(dst + 13'(i))] !== pat(src + 16'(i))) bad++;
        chk(req, bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 status", {24'h0, reg_rdata}, 32'hFF);
        chk("R9 busy", busy, 0);
        chk("R9 req/we", {mem_req, vram_we}, 0);
        reg_addr = 3'd0; #1;
        chk("R8 other index", {24'h0, reg_rdata}, 32'hFF);
        reg_addr = 3'd4;
    endtask

    task automatic t_general;
        int w0;
        mem_gnt = 1'b0;
        setup(16'h1234, 16'hC12F);
        wr(3'd4, 8'h02);
        w0 = wcnt;
        chk("R8 status mid", {24'h0, reg_rdata}, 32'h02);
        chk("R11 req with grant low", mem_req, 1);
        chk("R11 no write without grant", vram_we, 0);
        mem_gnt = 1'b1;
        wait_idle(200);
        chk("R5 general count", wcnt - w0, 48);
        chk("R8 status done", {24'h0, reg_rdata}, 32'hFF);
        data_chk("R1 R2 R5 general data", 16'h1230, 13'h0120, 48);
    endtask

    task automatic t_stall;
        int w0, grants;
        grants = 0;
        setup(16'h3300, 16'h8A00);
        wr(3'd4, 8'h00);
        w0 = wcnt;
        for (int n = 0; n < 100 && busy; n++) begin
            mem_gnt = n[0];
            #1;
            if (busy && mem_gnt) grants++;
            @(negedge clk);
        end
        mem_gnt = 1'b1;
        chk("R5 one byte per grant", grants, 16);
        chk("R3 R5 stalled count", wcnt - w0, 16);
        data_chk("R5 stalled data", 16'h3300, 13'h0A00, 16);
    endtask

    task automatic t_hblank;
        int w0;
        setup(16'h4000, 16'h8800);
        wr(3'd4, 8'h81);
        w0 = wcnt;
        repeat (5) @(negedge clk);
        chk("R6 no move before edge", wcnt - w0, 0);
        chk("R11 idle between bursts", busy, 0);
        chk("R8 status hbl", {24'h0, reg_rdata}, 32'h01);
        hblank = 1'b1;
        repeat (40) @(negedge clk);
        chk("R4 R6 one burst on held level", wcnt - w0, 16);
        chk("R8 status one left", {24'h0, reg_rdata}, 32'h00);
        hblank = 1'b0;
        repeat (3) @(negedge clk);
        hblank = 1'b1;
        repeat (20) @(negedge clk);
        hblank = 1'b0;
        chk("R6 second burst", wcnt - w0, 32);
        chk("R6 done status", {24'h0, reg_rdata}, 32'hFF);
        data_chk("R6 hbl data", 16'h4000, 13'h0800, 32);
    endtask

    task automatic t_cancel;
        int w0;
        setup(16'h5000, 16'h8000);
        wr(3'd4, 8'h83);
        w0 = wcnt;
        @(negedge clk); hblank = 1'b1;
        repeat (2) @(negedge clk); hblank = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 first burst", wcnt - w0, 16);
        chk("R8 three left", {24'h0, reg_rdata}, 32'h02);
        wr(3'd4, 8'h00);
        chk("R7 cancelled status", {24'h0, reg_rdata}, 32'hFF);
        @(negedge clk); hblank = 1'b1;
        repeat (2) @(negedge clk); hblank = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 no move after cancel", wcnt - w0, 16);
        chk("R7 busy after cancel", busy, 0);
        wr(3'd4, 8'h00);
        wait_idle(100);
        chk("R7 idle write starts general", wcnt - w0, 32);
    endtask

    task automatic t_regs_live;
        mem_gnt = 1'b0;
        setup(16'h2200, 16'h8400);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h77); wr(3'd1, 8'h70);
        wr(3'd2, 8'h99); wr(3'd3, 8'h50);
        mem_gnt = 1'b1;
        wait_idle(100);
        data_chk("R10 working counters kept", 16'h2200, 13'h0400, 16);
    endtask

    task automatic t_max;
        int w0;
        mem_gnt = 1'b0;
        setup(16'h0000, 16'h9F00);
        wr(3'd4, 8'h7F);
        w0 = wcnt;
        chk("R3 R8 max status", {24'h0, reg_rdata}, 32'h7F);
        mem_gnt = 1'b1;
        wait_idle(3000);
        chk("R3 max count", wcnt - w0, 2048);
        data_chk("R2 window wrap data", 16'h0000, 13'h1F00, 2048);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        nchk++; nerr++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_general();
        t_stall();
        t_hblank();
        t_cancel();
        t_regs_live();
        t_max();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule